// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Interrupt Unit

This block watches a running calendar clock and decides, once per clock update, whether either of two programmed alarm settings is due. Each alarm setting is four bytes: seconds, minutes, hours and day. The top bit of each byte is a per-field "don't care" mask. Masking fields from the day downward makes an alarm repeat every second, every minute, every hour, every day or once a week. A due alarm sets a sticky request flag. The flag drops when the host interface points at any register of that alarm's set, whether to read it or to write it.

The two alarms signal the processor in different ways. Alarm 0 drives an active-low level that stays asserted for as long as its flag and its enable are both high. Alarm 1 drives an active-high pulse of fixed length, counted in ticks of a 32.768 kHz timebase. The default of 2048 ticks gives 62.5 ms. Alarm 1 can only raise its flag while the part runs from its secondary or battery supply.

Top module: `alarm_irq_unit`

## Requirements
- R1: An alarm field whose bit 7 is 1 matches any clock value. A field whose bit 7 is 0 matches only when its bits 6:0 equal bits 6:0 of the clock field. Bit 7 of the clock field is never compared.
- R2: Each alarm vector holds seconds in bits 7:0, minutes in 15:8, hours in 23:16 and day in 31:24. An alarm is due only when all four fields match. With all four masks set it is due on every update. Mask patterns 0111, 0011, 0001 and 0000 (seconds/minutes/hours/day) require seconds; minutes and seconds; hours, minutes and seconds; and all four fields to match, respectively.
- R3: The comparison takes place only in a cycle with `upd_i` high. A due alarm sets its flag at that clock edge, and one update sets each flag at most once. With no update and no access, a flag holds its value.
- R4: `irq0_n_o` is 0 exactly while `flag0_o` is 1 and `en0_i` is 1. Otherwise it is 1.
- R5: When flag 1 is set while `en1_i` is 1, `irq1_o` goes high in the next cycle. It stays high until `PULSE_TICKS` cycles with `tick_i` high have passed, counting from the cycle after the set. While `tick_i` is low the pulse does not shorten.
- R6: While `en1_i` is 0, `irq1_o` is 0 and any pulse in progress is cancelled. While `en0_i` is 0, `irq0_n_o` is 1.
- R7: A cycle with `acc0_i` (or `acc1_i`) high clears flag 0 (or flag 1) at the next edge.
- R8: Flag 0 may be set whatever the supply. Flag 1 may be set only while `on_backup_i` is 1.
- R9: When an access clear and a new match for the same alarm fall in one cycle, the flag is set.
- R10: After reset both flags are 0, `irq0_n_o` is 1 and `irq1_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz timebase enable |
| upd_i | input | 1 | Clock update strobe, once per second |
| cur_sec_i | input | 8 | Current seconds |
| cur_min_i | input | 8 | Current minutes |
| cur_hour_i | input | 8 | Current hours |
| cur_day_i | input | 8 | Current day |
| alm0_i | input | 32 | Alarm 0 setting {day, hour, min, sec} |
| alm1_i | input | 32 | Alarm 1 setting {day, hour, min, sec} |
| en0_i | input | 1 | Alarm 0 interrupt enable |
| en1_i | input | 1 | Alarm 1 interrupt enable |
| acc0_i | input | 1 | Host pointer addresses an alarm 0 register |
| acc1_i | input | 1 | Host pointer addresses an alarm 1 register |
| on_backup_i | input | 1 | Running from secondary or battery supply |
| flag0_o | output | 1 | Alarm 0 request flag |
| flag1_o | output | 1 | Alarm 1 request flag |
| irq0_n_o | output | 1 | Alarm 0 level interrupt, active low |
| irq1_o | output | 1 | Alarm 1 pulse interrupt, active high |

## Verification
The matcher is swept over all sixteen mask patterns crossed with all sixteen choices of which fields differ from the clock. This separates a field that is masked from one that truly matches, and it shows that each mask bit applies to its own byte. Bit 7 of the clock value alternates across the sweep, so a design that compared it would fail. Separate sequences take the flags through clear-only, clear-with-set and set-without-backup cycles. They also run the alarm 1 pulse with a steady timebase, which checks its exact length, and with a stalled timebase and an enable dropped mid-pulse, which check that the pulse holds and that it is cancelled.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int NUM_FIELDS = 4;
    localparam int FIELD_W    = 8;
    localparam int VEC_W      = NUM_FIELDS * FIELD_W;
    localparam int NUM_ALARMS = 2;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_irq_pkg::*;
#(
    parameter int N_FIELDS = NUM_FIELDS,
    parameter int F_W      = FIELD_W
) (
    input  logic [N_FIELDS*F_W-1:0] cur_i,
    input  logic [N_FIELDS*F_W-1:0] alm_i,
    output logic                    hit_o
);
    localparam int MASK_BIT = F_W - 1;
    localparam int VAL_W    = F_W - 1;

    logic [N_FIELDS-1:0] field_ok;

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        logic [VAL_W-1:0] cur_val;
        logic [VAL_W-1:0] alm_val;
        logic             masked;
        always_comb begin
            cur_val     = cur_i[f*F_W +: VAL_W];
            alm_val     = alm_i[f*F_W +: VAL_W];
            masked      = alm_i[f*F_W + MASK_BIT];
            field_ok[f] = masked || (cur_val == alm_val);
        end
    end

    assign hit_o = &field_ok;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic hit_i,
    input  logic allow_i,
    input  logic acc_i,
    output logic set_o,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     set_ev;

    always_comb begin
        set_ev = upd_i && hit_i && allow_i;
        st_d   = st_q;
        if (acc_i) begin
            st_d.flag = 1'b0;
        end
        if (set_ev) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign set_o  = set_ev;
    assign flag_o = st_q.flag;

    AST_FLAG_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && hit_i && allow_i) |=> flag_o); // R3
    AST_FLAG_CLEAR_ON_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !(upd_i && hit_i && allow_i)) |=> !flag_o); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !acc_i) |=> $stable(flag_o)); // R3
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse #(
    parameter int PULSE_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic tick_i,
    output logic active_o
);
    localparam int            CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(PULSE_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (start_i) begin
            st_d.cnt = LOAD_V;
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.cnt != '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LOAD_V); // R5
    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_i) |=> active_o); // R5
    AST_PULSE_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && en_i && !tick_i) |=> active_o); // R5
    AST_PULSE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !active_o); // R6
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
    import alarm_irq_pkg::*;
#(
    parameter int PULSE_TICKS = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             upd_i,
    input  logic [FIELD_W-1:0] cur_sec_i,
    input  logic [FIELD_W-1:0] cur_min_i,
    input  logic [FIELD_W-1:0] cur_hour_i,
    input  logic [FIELD_W-1:0] cur_day_i,
    input  logic [VEC_W-1:0] alm0_i,
    input  logic [VEC_W-1:0] alm1_i,
    input  logic             en0_i,
    input  logic             en1_i,
    input  logic             acc0_i,
    input  logic             acc1_i,
    input  logic             on_backup_i,
    output logic             flag0_o,
    output logic             flag1_o,
    output logic             irq0_n_o,
    output logic             irq1_o
);
    logic [VEC_W-1:0]      cur_vec;
    logic [VEC_W-1:0]      alm_vec [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] allow;
    logic [NUM_ALARMS-1:0] acc;
    logic [NUM_ALARMS-1:0] set_ev;
    logic [NUM_ALARMS-1:0] flag;
    logic                  pulse_active;

    always_comb begin
        cur_vec    = {cur_day_i, cur_hour_i, cur_min_i, cur_sec_i};
        alm_vec[0] = alm0_i;
        alm_vec[1] = alm1_i;
        allow      = {on_backup_i, 1'b1};
        acc        = {acc1_i, acc0_i};
    end

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_match #(
            .N_FIELDS (NUM_FIELDS),
            .F_W      (FIELD_W)
        ) i_match (
            .cur_i (cur_vec),
            .alm_i (alm_vec[a]),
            .hit_o (hit[a])
        );

        alarm_flag i_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_i   (upd_i),
            .hit_i   (hit[a]),
            .allow_i (allow[a]),
            .acc_i   (acc[a]),
            .set_o   (set_ev[a]),
            .flag_o  (flag[a])
        );
    end

    alarm_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) i_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en1_i),
        .start_i  (set_ev[1]),
        .tick_i   (tick_i),
        .active_o (pulse_active)
    );

    assign flag0_o  = flag[0];
    assign flag1_o  = flag[1];
    assign irq0_n_o = !(flag[0] && en0_i);
    assign irq1_o   = pulse_active && en1_i;

    AST_ALL_MASKED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && alm0_i[7] && alm0_i[15] && alm0_i[23] && alm0_i[31]) |=> flag0_o); // R1
    AST_NO_SET_OFF_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_backup_i && !flag1_o) |=> !flag1_o); // R8
    AST_IRQ1_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en1_i |-> !irq1_o); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && hit[0] && acc0_i) |=> flag0_o); // R9
endmodule

// File: tb/test_alarm_irq_unit.sv
module test_alarm_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PT         = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, upd_i = 1'b0;
    logic [7:0]  cur_sec_i = '0, cur_min_i = '0, cur_hour_i = '0, cur_day_i = '0;
    logic [31:0] alm0_i = '0, alm1_i = '0;
    logic        en0_i = 1'b0, en1_i = 1'b0, acc0_i = 1'b0, acc1_i = 1'b0, on_backup_i = 1'b0;
    logic        flag0_o, flag1_o, irq0_n_o, irq1_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_unit #(.PULSE_TICKS(PT)) i_alarm_irq_unit (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .upd_i(upd_i),
        .cur_sec_i(cur_sec_i), .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i),
        .cur_day_i(cur_day_i), .alm0_i(alm0_i), .alm1_i(alm1_i),
        .en0_i(en0_i), .en1_i(en1_i), .acc0_i(acc0_i), .acc1_i(acc1_i),
        .on_backup_i(on_backup_i), .flag0_o(flag0_o), .flag1_o(flag1_o),
        .irq0_n_o(irq0_n_o), .irq1_o(irq1_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_update();
        upd_i = 1'b1;
        step();
        upd_i = 1'b0;
    endtask

    task automatic clear_both();
        acc0_i = 1'b1; acc1_i = 1'b1;
        step();
        acc0_i = 1'b0; acc1_i = 1'b0;
    endtask

    task automatic set_time(input int i);
        cur_sec_i  = 8'(i % 60)       | ((i % 2) != 0 ? 8'h80 : 8'h00);
        cur_min_i  = 8'((i * 3) % 60) | ((i % 2) != 0 ? 8'h80 : 8'h00);
        cur_hour_i = 8'(i % 24);
        cur_day_i  = 8'(1 + i % 7)    | ((i % 2) != 0 ? 8'h80 : 8'h00);
    endtask

    function automatic logic [31:0] make_alarm(input logic [3:0] mask, input logic [3:0] diff);
        logic [7:0] c [4];
        logic [31:0] v;
        c[0] = cur_sec_i; c[1] = cur_min_i; c[2] = cur_hour_i; c[3] = cur_day_i;
        v = '0;
        for (int f = 0; f < 4; f++) begin
            logic [6:0] val;
            val = diff[f] ? (c[f][6:0] ^ 7'h01) : c[f][6:0];
            v[f*8 +: 8] = {mask[f], val};
        end
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len;
        step();
        // R10 reset state
        chk("R10 flag0", int'(flag0_o), 0);
        chk("R10 flag1", int'(flag1_o), 0);
        chk("R10 irq0_n", int'(irq0_n_o), 1);
        chk("R10 irq1", int'(irq1_o), 0);
        rst_n = 1'b1;
        step();

        // R1 R2 R3 R7 R4 sweep: mask x differing fields
        en0_i = 1'b1; en1_i = 1'b0; on_backup_i = 1'b1;
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 16; d++) begin
                int exp_hit;
                set_time(m * 16 + d);
                alm0_i = make_alarm(4'(m), 4'(d));
                alm1_i = make_alarm(4'(m), 4'(d));
                exp_hit = ((~m & d & 15) == 0) ? 1 : 0;
                step();
                chk("R3 no update no flag", int'(flag0_o), 0);
                do_update();
                chk("R1 R2 flag0 after update", int'(flag0_o), exp_hit);
                chk("R1 R2 flag1 after update", int'(flag1_o), exp_hit);
                chk("R4 irq0_n level", int'(irq0_n_o), 1 - exp_hit);
                clear_both();
                chk("R7 flag0 cleared", int'(flag0_o), 0);
                chk("R7 flag1 cleared", int'(flag1_o), 0);
            end
        end

        // R3 hold without update/access
        set_time(5);
        alm0_i = 32'h80808080; alm1_i = 32'h80808080;
        do_update();
        repeat (4) step();
        chk("R3 flag0 holds", int'(flag0_o), 1);
        chk("R3 flag1 holds", int'(flag1_o), 1);
        // R6 en0 low keeps irq0_n high
        en0_i = 1'b0;
        step();
        chk("R6 irq0_n with en0=0", int'(irq0_n_o), 1);
        en0_i = 1'b1;
        step();
        chk("R4 irq0_n re-enabled", int'(irq0_n_o), 0);
        // R9 set beats clear
        acc0_i = 1'b1; acc1_i = 1'b1; upd_i = 1'b1;
        step();
        acc0_i = 1'b0; acc1_i = 1'b0; upd_i = 1'b0;
        chk("R9 flag0 set wins", int'(flag0_o), 1);
        chk("R9 flag1 set wins", int'(flag1_o), 1);
        // R7 independent clears
        acc0_i = 1'b1;
        step();
        acc0_i = 1'b0;
        chk("R7 acc0 clears flag0", int'(flag0_o), 0);
        chk("R7 acc0 leaves flag1", int'(flag1_o), 1);
        clear_both();

        // R8 no flag1 set off backup
        on_backup_i = 1'b0;
        do_update();
        chk("R8 flag0 sets on any supply", int'(flag0_o), 1);
        chk("R8 flag1 blocked on primary", int'(flag1_o), 0);
        clear_both();
        on_backup_i = 1'b1;

        // R5 pulse length with steady tick
        en1_i = 1'b1; tick_i = 1'b1;
        do_update();
        len = 0;
        for (int k = 0; k < 3 * PT; k++) begin
            if (irq1_o) len++;
            step();
        end
        chk("R5 pulse length cycles", len, PT);
        chk("R5 pulse ended", int'(irq1_o), 0);
        clear_both();

        // R5 stalled tick holds pulse
        tick_i = 1'b0;
        do_update();
        repeat (20) step();
        chk("R5 pulse held without tick", int'(irq1_o), 1);
        tick_i = 1'b1;
        repeat (PT - 1) step();
        chk("R5 pulse still high before last tick", int'(irq1_o), 1);
        step();
        chk("R5 pulse ends on last tick", int'(irq1_o), 0);
        clear_both();

        // R6 en1 low: no pulse, and cancel mid-pulse
        en1_i = 1'b0; tick_i = 1'b0;
        do_update();
        repeat (3) step();
        chk("R6 irq1 low with en1=0", int'(irq1_o), 0);
        chk("R6 flag1 still sets", int'(flag1_o), 1);
        clear_both();
        en1_i = 1'b1;
        do_update();
        chk("R5 pulse starts", int'(irq1_o), 1);
        en1_i = 1'b0;
        step();
        en1_i = 1'b1;
        step();
        chk("R6 pulse cancelled", int'(irq1_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule